// File: doc/BRIEF.md
# Five-Port Bidirectional GPIO Bank

This block gives a small microcontroller forty general-purpose pins grouped as five 8-bit ports, numbered 0 to 4 (A to E). Each port has one data latch and one direction register, both reached over a simple byte-wide register bus. A direction bit set to 1 makes its pin an input. A direction bit cleared to 0 makes the pin drive its latch value. Reading a port returns the synchronised pad level on input pins and the latch on output pins. Because of that, a read-modify-write of a single bit leaves the other output values as they were.

Pins are numbered globally as `port*8 + bit`. Three pins of port E (pins 34 to 36) are output-only. Port C bits 0 and 1 (pins 16 and 17) drive as open-drain. Port C bit 2 (pin 18) also feeds an edge detector that raises a one-cycle interrupt pulse. Bit 0 of port E's latch selects the active edge of that detector. Port A and the low half of port C raise a level wake-up request when their synchronised input differs from a stored snapshot. Software retakes the snapshot, which clears the request, by writing the address just above the last direction register.

Top module: `gpio_bank`

## Requirements
- R1: The latch of port p is at address 0x12+2p and its direction register at 0x13+2p, for p = 0..4. A write with `wr_en` high updates the addressed register at the next clock edge. A read of a direction register returns the value last written to it.
- R2: On a pin other than pins 16, 17 and 34 to 36, a direction bit of 1 sets `pad_oe` low, and a direction bit of 0 sets `pad_oe` high with `pad_out` equal to the latch bit.
- R3: A read of a latch address returns, bit by bit, the synchronised pad level where the direction bit is 1 and the latch where it is 0. A pad change shows in the read value after two rising clock edges.
- R4: A latch keeps its value through writes to other addresses and through any number of idle cycles.
- R5: After reset every direction bit is 1 and every latch bit is 1. The synchroniser, snapshot and edge-detector flops reset to the `PULL_HIGH` parameter value.
- R6: `ext_irq` pulses high for exactly one cycle on a rising synchronised edge of pin 18 when latch bit 32 (port E bit 0) is 1, and on a falling edge when it is 0. An edge of the other direction gives no pulse.
- R7: Pins 34, 35 and 36 always drive (`pad_oe` = 1, `pad_out` = latch) whatever their direction bits hold. Reads of these bits return the latch.
- R8: Pins 16 and 17 are open-drain: `pad_out` is 0, and `pad_oe` is high only when the direction bit is 0 and the latch bit is 0.
- R9: `wake_req` is high while any of pins 0 to 7 or 16 to 19 differs from its snapshot. A write to address 0x1C loads the snapshot from the synchronised pins and so clears the request. Changes on the other pins never raise it.
- R10: `rdata` is 0 when `rd_en` is low, and also when `rd_en` is high and the address is outside 0x12 to 0x1B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| pad_in | input | 40 | Pad levels, pin n = port*8+bit |
| pad_out | output | 40 | Pad output values |
| pad_oe | output | 40 | Pad output enables |
| wake_req | output | 1 | Wake-up request |
| ext_irq | output | 1 | One-cycle external interrupt pulse |

## Verification
The hardest case to reach from the ports is the interrupt edge under each polarity setting. To reach it, the polarity pin has to be made an output and written, pin 18 has to be an input, and the pad has to move in both directions while the bench counts pulses at the falling clock edge. The bench flips the polarity between rounds and drives each edge direction once per round, so that a wrong edge or a pulse longer than one cycle changes the count. For wake-up, the bench toggles every one of the forty pins alone, so it checks both the enabled set and the pins that must stay silent. It also retakes the snapshot while a pin is still toggled.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int         PORT_W    = 8,
  parameter logic [7:0] BASE_ADDR = 8'h12,
  parameter bit         PULL_HIGH = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [7:0]            addr,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  input  logic [5*PORT_W-1:0]   pad_in,
  output logic [5*PORT_W-1:0]   pad_out,
  output logic [5*PORT_W-1:0]   pad_oe,
  output logic                  wake_req,
  output logic                  ext_irq
);
  localparam int NPORTS = 5;
  localparam int NPINS  = NPORTS * PORT_W;
  localparam logic [7:0] SNAP_ADDR = 8'(BASE_ADDR + 2 * NPORTS);
  localparam int PIN_OD0 = 2 * PORT_W;
  localparam int PIN_IRQ = 2 * PORT_W + 2;
  localparam int PIN_POL = 4 * PORT_W;

  function automatic logic [NPINS-1:0] mask_range(input int lo, input int hi);
    logic [NPINS-1:0] m;
    m = '0;
    for (int i = lo; i <= hi; i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [NPINS-1:0] OUT_ONLY = mask_range(4*PORT_W+2, 4*PORT_W+4);
  localparam logic [NPINS-1:0] OPEN_DR  = mask_range(PIN_OD0, PIN_OD0+1);
  localparam logic [NPINS-1:0] WAKE_EN  = mask_range(0, PORT_W-1) | mask_range(2*PORT_W, 2*PORT_W+3);
  localparam logic [NPINS-1:0] IDLE_LVL = {NPINS{PULL_HIGH}};

  logic [NPINS-1:0] latch_q, ctrl_q;
  logic [NPINS-1:0] sync1_q, sync2_q, snap_q;
  logic             irq_prev_q;
  logic [NPINS-1:0] rd_view, as_output;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      ctrl_q  <= '1;
    end else if (wr_en) begin
      for (int p = 0; p < NPORTS; p++) begin
        if (addr == 8'(BASE_ADDR + 2*p))     latch_q[p*PORT_W +: PORT_W] <= wdata[PORT_W-1:0];
        if (addr == 8'(BASE_ADDR + 2*p + 1)) ctrl_q[p*PORT_W +: PORT_W]  <= wdata[PORT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q    <= IDLE_LVL;
      sync2_q    <= IDLE_LVL;
      snap_q     <= IDLE_LVL;
      irq_prev_q <= PULL_HIGH;
    end else begin
      sync1_q    <= pad_in;
      sync2_q    <= sync1_q;
      irq_prev_q <= sync2_q[PIN_IRQ];
      if (wr_en && addr == SNAP_ADDR) snap_q <= sync2_q;
    end
  end

  assign as_output = ~ctrl_q | OUT_ONLY;
  assign rd_view   = (as_output & latch_q) | (~as_output & sync2_q);

  genvar g;
  generate
    for (g = 0; g < NPINS; g++) begin : g_pin
      if (OPEN_DR[g]) begin : g_od
        assign pad_out[g] = 1'b0;
        assign pad_oe[g]  = ~ctrl_q[g] & ~latch_q[g];
      end else begin : g_pp
        assign pad_out[g] = latch_q[g];
        assign pad_oe[g]  = as_output[g];
      end
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      for (int p = 0; p < NPORTS; p++) begin
        if (addr == 8'(BASE_ADDR + 2*p))     rdata = 8'(rd_view[p*PORT_W +: PORT_W]);
        if (addr == 8'(BASE_ADDR + 2*p + 1)) rdata = 8'(ctrl_q[p*PORT_W +: PORT_W]);
      end
    end
  end

  assign wake_req = |((sync2_q ^ snap_q) & WAKE_EN);

  assign ext_irq = latch_q[PIN_POL] ?  (sync2_q[PIN_IRQ] & ~irq_prev_q)
                                    :  (~sync2_q[PIN_IRQ] & irq_prev_q);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NPINS = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [7:0]       addr,
  input logic [7:0]       rdata,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] latch_q,
  input logic [NPINS-1:0] ctrl_q
);
  localparam logic [NPINS-1:0] PLAIN = ~((NPINS'(7) << 34) | (NPINS'(3) << 16));

  a_r2_input_released: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ctrl_q & PLAIN) == '0);

  a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(latch_q));

  a_r7_out_only_drive: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe[36:34] == 3'b111 && pad_out[36:34] == latch_q[36:34]);

  a_r8_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe[17:16] & latch_q[17:16]) == 2'b00);

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 8'h00);

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr < 8'h12 || addr > 8'h1B)) |-> rdata == 8'h00);
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(40)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .pad_oe(pad_oe), .pad_out(pad_out),
  .latch_q(latch_q), .ctrl_q(ctrl_q)
);

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic [7:0]  rdata;
  logic [39:0] pad_v = '1;
  logic [39:0] pad_out, pad_oe;
  logic        wake_req, ext_irq;

  logic [39:0] m_lat = '1, m_ctl = '1;
  int vectors = 0, fails = 0, irq_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_v), .pad_out(pad_out),
    .pad_oe(pad_oe), .wake_req(wake_req), .ext_irq(ext_irq)
  );

  always @(negedge clk) if (rst_n && ext_irq) irq_cnt++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    for (int p = 0; p < 5; p++) begin
      if (a == 8'(8'h12 + 2*p)) m_lat[p*8 +: 8] = d;
      if (a == 8'(8'h13 + 2*p)) m_ctl[p*8 +: 8] = d;
    end
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic bit out_only(input int i); return i >= 34 && i <= 36; endfunction
  function automatic bit od_pin(input int i); return i == 16 || i == 17; endfunction
  function automatic bit wake_pin(input int i); return i < 8 || (i >= 16 && i <= 19); endfunction

  function automatic logic [39:0] exp_oe();
    logic [39:0] e;
    for (int i = 0; i < 40; i++)
      e[i] = out_only(i) ? 1'b1 : od_pin(i) ? (!m_ctl[i] && !m_lat[i]) : !m_ctl[i];
    return e;
  endfunction

  function automatic logic [39:0] exp_out();
    logic [39:0] e;
    for (int i = 0; i < 40; i++) e[i] = od_pin(i) ? 1'b0 : m_lat[i];
    return e;
  endfunction

  function automatic logic [7:0] exp_rd(input int p);
    logic [7:0] e;
    for (int b = 0; b < 8; b++) begin
      int i = p*8 + b;
      e[b] = (out_only(i) || !m_ctl[i]) ? m_lat[i] : pad_v[i];
    end
    return e;
  endfunction

  task automatic check_all(input string tag);
    logic [7:0] d;
    for (int p = 0; p < 5; p++) begin
      rd(8'(8'h12 + 2*p), d); chk({tag, " R3 data read"}, 64'(d), 64'(exp_rd(p)));
      rd(8'(8'h13 + 2*p), d); chk({tag, " R1 ctrl read"}, 64'(d), 64'(m_ctl[p*8 +: 8]));
    end
    chk({tag, " R2 pad_oe"}, 64'(pad_oe), 64'(exp_oe()));
    chk({tag, " R8 pad_out"}, 64'(pad_out), 64'(exp_out()));
  endtask

  initial begin
    #2_000_000;
    vectors++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] d;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R5: reset state
    check_all("R5 reset");
    chk("R5 wake idle", 64'(wake_req), 64'(0));

    // R1 R2 R3 R7 R8: sweep patterns per port
    for (int k = 0; k < 32; k++) begin
      for (int p = 0; p < 5; p++) begin
        wr(8'(8'h13 + 2*p), 8'((k*37 + p*11) & 8'hFF));
        wr(8'(8'h12 + 2*p), 8'((k*91 + p*53 + 7) & 8'hFF));
      end
      pad_v = {8'((k*29+3)), 8'((k*13+1)), 8'((k*71+5)), 8'((k*17+9)), 8'((k*59+2))};
      idle(3);
      check_all("R2 sweep");
    end

    // R7: output-only pins ignore direction bits
    wr(8'h1B, 8'hFF); wr(8'h1A, 8'b0001_0100);
    idle(1);
    chk("R7 oe", 64'(pad_oe[36:34]), 64'(3'b111));
    chk("R7 out", 64'(pad_out[36:34]), 64'(3'b101));
    pad_v[36:34] = 3'b010; idle(3);
    rd(8'h1A, d); chk("R7 read latch", 64'(d[4:2]), 64'(3'b101));

    // R8: open-drain states
    for (int v = 0; v < 4; v++) begin
      wr(8'h17, {6'b0, v[0], v[0]});
      wr(8'h16, {6'b0, v[1], ~v[1]});
      chk("R8 od oe", 64'(pad_oe[17:16]), 64'(exp_oe() >> 16) & 64'h3);
      chk("R8 od out", 64'(pad_out[17:16]), 64'(0));
    end

    // R4: latch holds across other writes and idle time
    wr(8'h13, 8'h00); wr(8'h12, 8'hC3);
    for (int a = 8'h14; a <= 8'h1B; a++) wr(8'(a), 8'(a * 7));
    wr(8'h13, 8'h00);
    idle(20);
    rd(8'h12, d); chk("R4 latch held", 64'(d), 64'(8'hC3));
    chk("R4 pad_out held", 64'(pad_out[7:0]), 64'(8'hC3));

    // R10: unmapped addresses and idle read strobe
    for (int a = 0; a < 256; a++) begin
      if (a < 8'h12 || a > 8'h1B) begin
        rd(8'(a), d); chk("R10 unmapped", 64'(d), 64'(0));
      end
    end
    @(negedge clk); rd_en = 1'b0; addr = 8'h13; #1 chk("R10 no strobe", 64'(rdata), 64'(0));

    // R9: wake-up per pin
    for (int i = 0; i < 40; i++) m_ctl[i] = 1'b1;
    for (int p = 0; p < 5; p++) wr(8'(8'h13 + 2*p), 8'hFF);
    wr(8'h1C, 8'h00); idle(1);
    chk("R9 cleared", 64'(wake_req), 64'(0));
    for (int i = 0; i < 40; i++) begin
      pad_v[i] = ~pad_v[i]; idle(3);
      chk("R9 pin toggle", 64'(wake_req), 64'(wake_pin(i)));
      pad_v[i] = ~pad_v[i]; idle(3);
      chk("R9 pin restore", 64'(wake_req), 64'(0));
    end
    pad_v[3] = ~pad_v[3]; idle(3);
    wr(8'h1C, 8'h00); idle(1);
    chk("R9 strobe clears", 64'(wake_req), 64'(0));
    pad_v[3] = ~pad_v[3]; idle(3);
    chk("R9 new mismatch", 64'(wake_req), 64'(1));
    wr(8'h1C, 8'h00); idle(1);

    // R6: interrupt edges under both polarities
    wr(8'h1B, 8'h00);
    for (int pol = 0; pol < 2; pol++) begin
      wr(8'h1A, 8'(pol));
      pad_v[18] = 1'b0; idle(4);
      irq_cnt = 0;
      pad_v[18] = 1'b1; idle(5);
      chk("R6 rising", 64'(irq_cnt), 64'(pol));
      irq_cnt = 0;
      pad_v[18] = 1'b0; idle(5);
      chk("R6 falling", 64'(irq_cnt), 64'(1 - pol));
    end

    summary();
  end
endmodule